// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Master

This block sits between a clocked host and a byte-wide asynchronous static RAM with 32K locations. The host hands over one request at a time (a write flag, a 15-bit address and a data byte) with a single-cycle request pulse. The block then produces the active-low chip-select, output-enable and write-strobe pins of the memory. It keeps the address steady, drives the shared data bus during writes, releases it before reads, and reports completion with a one-cycle done pulse. On reads, the done pulse carries the byte read from memory.

The memory's timing minimums are parameters given in nanoseconds: address access, output-enable access, write-strobe width, data setup to write end, address hold after write end, and full cycle time. Each minimum is divided by the clock period and rounded up to whole cycles. Where the write-strobe width and the hold do not add up to the full cycle time, the block lengthens the hold phase.

Top module: `sram_mst`

## Requirements
- R1: After reset, `busy` and `done` are 0, `memCeN`, `memOeN` and `memWeN` are 1 (all strobes are active low), and `dqDriveEn` is 0.
- R2: A request (`reqValid` high while `busy` is low) is taken at the next rising edge. `busy` is then 1 until the cycle in which `done` is 1. `done` is high for exactly one cycle, and `busy` is 0 in that cycle.
- R3: A read (`reqWrite`=0) returns on `rdData`, in the cycle `done` is high, the byte stored at `reqAddr`.
- R4: A write (`reqWrite`=1) stores `reqWdata` at `reqAddr`, and a later read of that address returns it.
- R5: `memOeN` stays 1 during the whole write cycle. `memWeN` is 0 only while `memCeN` is 0.
- R6: `memWeN` stays low for at least ceil(WP_NS/CLK_NS) cycles. Write data is driven for at least DS_NS before `memWeN` rises, and it is still driven in the cycle in which `memWeN` rises.
- R7: `memAddr` does not change while `memCeN` is low. It also does not change within AH_NS after `memWeN` rises. Every chip-select low period lasts at least CYC_NS.
- R8: `dqDriveEn` is 0 whenever `memOeN` is 0, and it is already 0 in the cycle before `memOeN` falls. Read data is sampled only after both ACC_NS from the address and OE_NS from the fall of `memOeN` have elapsed.
- R9: A request raised while `busy` is 1 is ignored: it gives no extra `done` and leaves memory contents unchanged.
- R10: A read issued in the cycle right after a write's `done` (and the reverse) completes correctly, without bus contention.
- R11: Count the rising edges from the one that accepts a request up to the one after which `done` is high, inclusive. For a read this count is N+3, where N = max(ceil(OE_NS/CLK_NS), ceil(ACC_NS/CLK_NS)-1). For a write it is P+H+3, where P = max(ceil(WP_NS/CLK_NS), ceil(DS_NS/CLK_NS)-1) and H = max(ceil(AH_NS/CLK_NS), ceil(CYC_NS/CLK_NS)-1-P).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request pulse from the host |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Request address |
| reqWdata | input | 8 | Byte to write |
| busy | output | 1 | Request in progress; new requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Read byte, valid while `done` is high after a read |
| memAddr | output | 15 | Address pins of the memory |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| dqOut | output | 8 | Data driven onto the shared bus |
| dqDriveEn | output | 1 | Enables the master's bus drivers |
| dqIn | input | 8 | Data seen on the shared bus |

## Verification
The bench builds the block with its default parameters: a 4 ns clock and minimums of 85/45/65/35/5/85 ns. These give a 21-cycle output-enable phase on reads and a 17-cycle write strobe. With these values the 5 ns address hold alone would give too short a write cycle, so the padding of the hold phase up to the cycle minimum is exercised. A behavioural memory in the bench measures every strobe interval in clock cycles. It returns corrupted data when it is read too early, so both the rounding of each interval and the padding can be observed at the ports.

// File: rtl/sram_mst_pkg.sv
package sram_mst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TURN,
    ST_RD_ACC,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_FINISH
  } ctrlState_t;

  // Strobes from control to datapath; all active high here.
  typedef struct packed {
    logic load;      // latch the request fields
    logic ceAct;     // chip select asserted
    logic oeAct;     // memory outputs enabled
    logic weAct;     // write strobe asserted
    logic driveAct;  // master drives the data bus
    logic complete;  // last cycle of the access
  } strobe_t;

  function automatic int cyclesFor(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_mst_ctrl.sv
module sram_mst_ctrl
  import sram_mst_pkg::*;
#(
  parameter int RD_N   = 21,
  parameter int WP_N   = 17,
  parameter int HOLD_N = 4,
  parameter int CNT_W  = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    busy,
  output strobe_t strobes
);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_N - 1);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_N - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_N - 1);

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic cntZero;

  assign cntZero = (cnt == '0);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.load = 1'b1;
          stateNext    = reqWrite ? ST_WR_SETUP : ST_RD_TURN;
        end
      end
      ST_RD_TURN: begin
        // bus already released; outputs of the memory still off
        strobes.ceAct = 1'b1;
        stateNext     = ST_RD_ACC;
        cntNext       = RD_LOAD;
      end
      ST_RD_ACC: begin
        strobes.ceAct = 1'b1;
        strobes.oeAct = 1'b1;
        if (cntZero) begin
          strobes.complete = 1'b1;
          stateNext        = ST_FINISH;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WR_SETUP: begin
        strobes.ceAct    = 1'b1;
        strobes.driveAct = 1'b1;
        stateNext        = ST_WR_PULSE;
        cntNext          = WP_LOAD;
      end
      ST_WR_PULSE: begin
        strobes.ceAct    = 1'b1;
        strobes.weAct    = 1'b1;
        strobes.driveAct = 1'b1;
        if (cntZero) begin
          stateNext = ST_WR_HOLD;
          cntNext   = HOLD_LOAD;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WR_HOLD: begin
        strobes.ceAct    = 1'b1;
        strobes.driveAct = 1'b1;
        if (cntZero) begin
          strobes.complete = 1'b1;
          stateNext        = ST_FINISH;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

endmodule

// File: rtl/sram_mst_dp.sv
module sram_mst_dp
  import sram_mst_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqDriveEn,
  input  logic [DATA_W-1:0] dqIn,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ;
  logic              completeQ;

  // Request fields: held until the next accepted request.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (strobes.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
    end
  end

  assign memAddr = addrQ;
  assign dqOut   = wdataQ;

  // Pin registers: glitch-free strobes, one cycle behind the control.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCeN    <= 1'b1;
      memOeN    <= 1'b1;
      memWeN    <= 1'b1;
      dqDriveEn <= 1'b0;
      completeQ <= 1'b0;
    end else begin
      memCeN    <= ~strobes.ceAct;
      memOeN    <= ~strobes.oeAct;
      memWeN    <= ~strobes.weAct;
      dqDriveEn <= strobes.driveAct;
      completeQ <= strobes.complete;
    end
  end

  // Read capture at the end of the last output-enabled pin cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done   <= 1'b0;
      rdData <= '0;
    end else begin
      done <= completeQ;
      if (completeQ && !writeQ) rdData <= dqIn;
    end
  end

endmodule

// File: rtl/sram_mst.sv
module sram_mst
  import sram_mst_pkg::*;
#(
  parameter int CLK_NS = 4,
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int ACC_NS = 85,
  parameter int OE_NS  = 45,
  parameter int WP_NS  = 65,
  parameter int DS_NS  = 35,
  parameter int AH_NS  = 5,
  parameter int CYC_NS = 85
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqDriveEn,
  input  logic [DATA_W-1:0] dqIn
);

  // Output-enable phase: address already stable one pin cycle earlier.
  localparam int RD_N = maxOf(maxOf(cyclesFor(OE_NS, CLK_NS),
                                    cyclesFor(ACC_NS, CLK_NS) - 1), 1);
  // Strobe width; data is on the bus one pin cycle before the strobe.
  localparam int WP_N = maxOf(maxOf(cyclesFor(WP_NS, CLK_NS),
                                    cyclesFor(DS_NS, CLK_NS) - 1), 1);
  // Hold phase, padded so the whole select period meets the cycle minimum.
  localparam int HOLD_N = maxOf(maxOf(cyclesFor(AH_NS, CLK_NS),
                                      cyclesFor(CYC_NS, CLK_NS) - 1 - WP_N), 1);
  localparam int CNT_W = $clog2(maxOf(maxOf(RD_N, WP_N), HOLD_N) + 1);

  strobe_t strobes;

  sram_mst_ctrl #(
    .RD_N  (RD_N),
    .WP_N  (WP_N),
    .HOLD_N(HOLD_N),
    .CNT_W (CNT_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .busy    (busy),
    .strobes (strobes)
  );

  sram_mst_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .dqOut    (dqOut),
    .dqDriveEn(dqDriveEn),
    .dqIn     (dqIn),
    .done     (done),
    .rdData   (rdData)
  );

endmodule

// File: rtl/sram_mst_chk.sv
module sram_mst_chk #(
  parameter int WP_N   = 17,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              dqDriveEn,
  input logic [ADDR_W-1:0] memAddr
);

  logic [15:0] weLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) weLowCnt <= '0;
    else if (!memWeN) begin
      if (weLowCnt != 16'hFFFF) weLowCnt <= weLowCnt + 1'b1;
    end else weLowCnt <= '0;
  end

  AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN); // R5
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R5
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= 16'(WP_N))); // R6
  AST_DATA_HELD_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> dqDriveEn); // R6
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr)); // R7
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !dqDriveEn); // R8
  AST_TURN_BEFORE_OE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memOeN) |-> $past(!dqDriveEn)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R2

endmodule

bind sram_mst sram_mst_chk #(
  .WP_N  (WP_N),
  .ADDR_W(ADDR_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .memCeN   (memCeN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .dqDriveEn(dqDriveEn),
  .memAddr  (memAddr)
);

// File: tb/sram_mst_test.sv
module sram_mst_test;

  localparam int CLK_NS = 4;
  localparam int ACC_NS = 85;
  localparam int OE_NS  = 45;
  localparam int WP_NS  = 65;
  localparam int DS_NS  = 35;
  localparam int AH_NS  = 5;
  localparam int CYC_NS = 85;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD  = mx(ceilDiv(OE_NS, CLK_NS), ceilDiv(ACC_NS, CLK_NS) - 1);
  localparam int P_WR  = mx(ceilDiv(WP_NS, CLK_NS), ceilDiv(DS_NS, CLK_NS) - 1);
  localparam int H_WR  = mx(ceilDiv(AH_NS, CLK_NS), ceilDiv(CYC_NS, CLK_NS) - 1 - P_WR);
  localparam int RD_LAT = N_RD + 3;
  localparam int WR_LAT = P_WR + H_WR + 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        busy, done;
  logic [7:0]  rdData;
  logic [14:0] memAddr;
  logic        memCeN, memOeN, memWeN;
  logic [7:0]  dqOut;
  logic        dqDriveEn;
  logic [7:0]  dqIn = '0;

  int checks = 0;
  int fails  = 0;
  int doneCount = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sram_mst uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done),
    .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .dqOut(dqOut), .dqDriveEn(dqDriveEn), .dqIn(dqIn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural memory with timing checks, sampled at the falling edge.
  logic [7:0] store [logic [14:0]];
  logic [14:0] prevAddr = '0;
  logic [7:0]  prevDq = '0;
  logic        prevWeN = 1'b1, prevCeN = 1'b1, prevDrive = 1'b0;
  int addrStable = 0, oeLow = 0, weLow = 0, ceLow = 0, dqStable = 0;
  int riseAge = 1000;

  function automatic logic [7:0] peek(input logic [14:0] a);
    return store.exists(a) ? store[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      addrStable = 0; oeLow = 0; weLow = 0; ceLow = 0; dqStable = 0;
      riseAge = 1000; prevWeN = 1'b1; prevCeN = 1'b1; prevDrive = 1'b0;
    end else begin
      if (done) doneCount++;
      if (!memOeN && dqDriveEn) check(0, "R8", "bus driven while memory outputs on", 1, 0);
      if (!memWeN && memCeN)    check(0, "R5", "write strobe outside select", 1, 0);
      if (!memWeN && !memOeN)   check(0, "R5", "output enable during write", 0, 1);
      addrStable = (memAddr == prevAddr) ? addrStable + 1 : 1;
      if (memAddr != prevAddr) begin
        if (!memCeN && !prevCeN) check(0, "R7", "address moved while selected", memAddr, prevAddr);
        if (riseAge * CLK_NS < AH_NS) check(0, "R7", "address hold after write", riseAge * CLK_NS, AH_NS);
      end
      oeLow = (!memOeN) ? oeLow + 1 : 0;
      dqStable = (dqDriveEn && prevDrive && dqOut == prevDq) ? dqStable + 1 : (dqDriveEn ? 1 : 0);
      if (riseAge < 1000) riseAge++;
      if (memWeN && !prevWeN) begin
        if (weLow * CLK_NS < WP_NS) check(0, "R6", "write strobe width ns", weLow * CLK_NS, WP_NS);
        if ((dqStable - 1) * CLK_NS < DS_NS) check(0, "R6", "data setup ns", (dqStable - 1) * CLK_NS, DS_NS);
        if (!dqDriveEn) check(0, "R6", "data released at strobe rise", 0, 1);
        if (!memCeN) store[memAddr] = dqOut;
        riseAge = 0;
      end
      weLow = (!memWeN) ? weLow + 1 : 0;
      if (memCeN && !prevCeN && ceLow * CLK_NS < CYC_NS)
        check(0, "R7", "select period ns", ceLow * CLK_NS, CYC_NS);
      ceLow = (!memCeN) ? ceLow + 1 : 0;
      if (!memCeN && !memOeN && memWeN && addrStable * CLK_NS >= ACC_NS && oeLow * CLK_NS >= OE_NS)
        dqIn = peek(memAddr);
      else
        dqIn = ~peek(memAddr) ^ 8'h3C;
      prevAddr = memAddr; prevDq = dqOut; prevWeN = memWeN;
      prevCeN = memCeN; prevDrive = dqDriveEn;
    end
  end

  // Issue one request at a falling edge; return latency in rising edges.
  task automatic issue(input logic wr, input logic [14:0] a, input logic [7:0] d,
                       output int lat);
    bit busyOk = 1;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!done && lat < 500) begin
      if (!busy) busyOk = 0;
      @(posedge clk); @(negedge clk);
      lat++;
    end
    check(busyOk, "R2", "busy held until done", busyOk, 1);
    check(done && !busy, "R2", "busy low with done", busy, 0);
  endtask

  task automatic doWrite(input logic [14:0] a, input logic [7:0] d);
    int lat;
    issue(1'b1, a, d, lat);
    check(lat == WR_LAT, "R11", "write latency", lat, WR_LAT);
    @(posedge clk); @(negedge clk);
    check(!done, "R2", "done single cycle", done, 0);
  endtask

  task automatic doRead(input logic [14:0] a, input logic [7:0] exp, input string req);
    int lat;
    issue(1'b0, a, 8'h00, lat);
    check(lat == RD_LAT, "R11", "read latency", lat, RD_LAT);
    check(rdData == exp, req, "read data", rdData, exp);
  endtask

  task automatic testReset();
    check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    check(memCeN && memOeN && memWeN, "R1", "strobes after reset", {memCeN, memOeN, memWeN}, 7);
    check(!dqDriveEn, "R1", "bus drive after reset", dqDriveEn, 0);
  endtask

  task automatic testPatterns();
    doRead(15'h0123, 8'h00, "R3");
    doWrite(15'h0000, 8'hA5);
    doWrite(15'h7FFF, 8'h5A);
    doWrite(15'h2AAA, 8'hFF);
    doWrite(15'h5555, 8'h00);
    doRead(15'h0000, 8'hA5, "R4");
    doRead(15'h7FFF, 8'h5A, "R4");
    doRead(15'h2AAA, 8'hFF, "R4");
    doRead(15'h5555, 8'h00, "R4");
    doWrite(15'h0000, 8'h3C);
    doRead(15'h0000, 8'h3C, "R4");
  endtask

  task automatic testBackToBack();
    // each issue starts in the cycle right after the previous done
    doWrite(15'h1234, 8'h81);
    doRead(15'h1234, 8'h81, "R10");
    doWrite(15'h1235, 8'h7E);
    doRead(15'h1235, 8'h7E, "R10");
    doRead(15'h1234, 8'h81, "R10");
  endtask

  task automatic testBusyIgnore();
    int startDone;
    int lat;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 15'h0100; reqWdata = 8'h11;
    @(posedge clk); @(negedge clk);
    startDone = doneCount;
    reqAddr = 15'h0200; reqWdata = 8'h22;  // held while busy
    lat = 1;
    while (!done && lat < 500) begin
      @(posedge clk); @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    repeat (40) begin @(posedge clk); @(negedge clk); end
    check(doneCount - startDone == 1, "R9", "dones for one accepted request",
          doneCount - startDone, 1);
    check(!busy, "R9", "idle after ignored request", busy, 0);
    doRead(15'h0200, 8'h00, "R9");
    doRead(15'h0100, 8'h11, "R4");
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPatterns();
    testBackToBack();
    testBusyIgnore();
    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule